// File: doc/BRIEF.md
# Serial Port Command and Enable Controller

This block sits behind a write-only command word of a serial port. Software never stores a value here. Each bit it writes as 1 is a one-shot command, and each bit it writes as 0 does nothing. The block turns these commands into two kinds of output. The first kind is a set of persistent enable levels: transmitter, receiver, FIFOs and the request-to-send request. The second kind is a set of one-clock pulses for the surrounding shifters, FIFOs and status logic. Those pulses reset a direction, flush a FIFO or clear the sticky error and event flags.

Each enable level is held by a two-state machine with the states `ST_OFF` and `ST_ON`. The transition `turn_on` leaves `ST_OFF` when the on-command is written and the matching off-command is not. The transition `turn_off` leaves `ST_ON` whenever the off-command is written. An off-command therefore always wins over an on-command in the same write. Every other case holds the current state.

The request-to-send pin shows the stored request through a polarity chosen by the port mode input. In the handshake mode (value 2) an active request drives the pin high. In every other mode, mode 0 included, an active request drives the pin low. The mode is applied combinationally, so changing it flips the pin at once.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: A cycle with `wr_en` low, and any command bit written as 0, leaves every enable level and the RTS request unchanged and raises no pulse.
- R2: Bit 0 turns the transmitter on and bit 1 turns it off. When both are written together, the transmitter ends up off.
- R3: Bit 2 turns the receiver on and bit 3 turns it off. When both are written together, the receiver ends up off.
- R4: Bit 4 enables the shared transmit/receive FIFO level and bit 5 disables it. When both are written together, the FIFOs end up disabled.
- R5: With `port_mode` = 2, bit 6 (assert request) drives `rts_out` high and bit 7 (release request) drives it low.
- R6: With `port_mode` other than 2 (0, 1 or 3), bit 6 drives `rts_out` low and bit 7 drives it high. When bits 6 and 7 are written together, the request ends up released.
- R7: After reset, the transmitter, receiver and FIFO levels are 0, every pulse output is 0, and `rts_out` sits at its released level for the current mode: low in mode 2, high otherwise.
- R8: Bit 8 raises `tx_reset_pulse` and bit 9 raises `rx_reset_pulse`. Each pulse is high for exactly the one cycle after the clock edge that samples the write, and neither command affects the other output.
- R9: Bit 10 raises `status_clear_pulse` for one cycle, with the same timing as R8.
- R10: Bit 11 raises `txf_flush_pulse` and bit 12 raises `rxf_flush_pulse`. Each is a single-cycle pulse that touches only its own FIFO.
- R11: Bits 13 to 31 are unassigned. Writing them changes no output.
- R12: Enable levels change at the clock edge that samples `wr_en`, so they are visible in the same cycle as the pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word; bits set to 1 act |
| port_mode | input | 2 | Port mode; value 2 selects active-high RTS |
| tx_enable | output | 1 | Transmitter enable level |
| rx_enable | output | 1 | Receiver enable level |
| fifo_enable | output | 1 | Transmit and receive FIFO enable level |
| rts_out | output | 1 | Request-to-send pin level |
| tx_reset_pulse | output | 1 | One-cycle transmitter reset |
| rx_reset_pulse | output | 1 | One-cycle receiver reset |
| status_clear_pulse | output | 1 | One-cycle clear of sticky error and event flags |
| txf_flush_pulse | output | 1 | One-cycle transmit FIFO flush |
| rxf_flush_pulse | output | 1 | One-cycle receive FIFO flush |

## Verification
The bench writes on and off commands together for each pair. A design that let the on-command win would leave the transmitter, receiver, FIFOs or RTS request active when they should be off. It toggles `port_mode` without writing, which catches RTS polarity latched at write time or inverted for the wrong mode. It also writes mode 1, which exposes a decode that treats only mode 0 as active-low. It checks each pulse one cycle after it fires, so a pulse that sticks high or leaks onto a neighbouring output fails. Writes of unassigned bits, and writes with the strobe low, catch decoding that ignores `wr_en` or aliases the upper word.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

    // Command bit positions inside the written word. Level channel k uses
    // bit 2k to turn on and bit 2k+1 to turn off.
    localparam int CMD_TX_ON      = 0;
    localparam int CMD_TX_OFF     = 1;
    localparam int CMD_RX_ON      = 2;
    localparam int CMD_RX_OFF     = 3;
    localparam int CMD_FIFO_ON    = 4;
    localparam int CMD_FIFO_OFF   = 5;
    localparam int CMD_RTS_ON     = 6;
    localparam int CMD_RTS_OFF    = 7;
    localparam int CMD_TX_RESET   = 8;
    localparam int CMD_RX_RESET   = 9;
    localparam int CMD_STAT_CLR   = 10;
    localparam int CMD_TXF_FLUSH  = 11;
    localparam int CMD_RXF_FLUSH  = 12;

    localparam int NUM_LEVELS     = 4;
    localparam int NUM_PULSES     = 5;
    localparam int PULSE_BASE     = 2 * NUM_LEVELS;
    localparam int CMD_W          = PULSE_BASE + NUM_PULSES;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } level_state_e;

endpackage

// File: rtl/uart_cmd_enable_fsm.sv
module uart_cmd_enable_fsm
    import uart_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_cmd,
    input  logic off_cmd,
    output logic active_o
);

    level_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: turn_on needs on without off, turn_off needs off
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (on_cmd && !off_cmd) state_d = ST_ON;
            ST_ON:  if (off_cmd)            state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        active_o = (state_q == ST_ON);
    end

    // R2
    off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_cmd |=> !active_o);

    // R2
    on_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_cmd && !off_cmd) |=> active_o);

    // R1
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_cmd && !off_cmd) |=> $stable(active_o));

endmodule

// File: rtl/uart_cmd_pulse_reg.sv
module uart_cmd_pulse_reg #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire_i,
    output logic [N-1:0] pulse_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_o <= '0;
        end else begin
            pulse_o <= fire_i;
        end
    end

    // R8
    pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i == '0) |=> (pulse_o == '0));

endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
    import uart_cmd_pkg::*;
#(
    parameter int              DATA_W  = 32,
    parameter int              MODE_W  = 2,
    parameter logic [MODE_W-1:0] HS_MODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MODE_W-1:0] port_mode,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic              fifo_enable,
    output logic              rts_out,
    output logic              tx_reset_pulse,
    output logic              rx_reset_pulse,
    output logic              status_clear_pulse,
    output logic              txf_flush_pulse,
    output logic              rxf_flush_pulse
);

    logic [CMD_W-1:0]      cmd_vec;
    logic [NUM_LEVELS-1:0] level_q;
    logic [NUM_PULSES-1:0] pulse_q;
    logic                  unused_hi;

    assign cmd_vec   = wr_en ? wr_data[CMD_W-1:0] : '0;
    assign unused_hi = ^wr_data[DATA_W-1:CMD_W];

    // one state machine per level channel
    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_level
        uart_cmd_enable_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .on_cmd   (cmd_vec[2*k]),
            .off_cmd  (cmd_vec[2*k+1]),
            .active_o (level_q[k])
        );
    end

    uart_cmd_pulse_reg #(.N(NUM_PULSES)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (cmd_vec[PULSE_BASE +: NUM_PULSES]),
        .pulse_o (pulse_q)
    );

    always_comb begin
        tx_enable          = level_q[CMD_TX_ON / 2];
        rx_enable          = level_q[CMD_RX_ON / 2];
        fifo_enable        = level_q[CMD_FIFO_ON / 2];
        rts_out            = (port_mode == HS_MODE) ? level_q[CMD_RTS_ON / 2]
                                                    : !level_q[CMD_RTS_ON / 2];
        tx_reset_pulse     = pulse_q[CMD_TX_RESET  - PULSE_BASE];
        rx_reset_pulse     = pulse_q[CMD_RX_RESET  - PULSE_BASE];
        status_clear_pulse = pulse_q[CMD_STAT_CLR  - PULSE_BASE];
        txf_flush_pulse    = pulse_q[CMD_TXF_FLUSH - PULSE_BASE];
        rxf_flush_pulse    = pulse_q[CMD_RXF_FLUSH - PULSE_BASE];
    end

    // R5
    rts_hs_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CMD_RTS_ON] && !wr_data[CMD_RTS_OFF])
        |=> ((port_mode != HS_MODE) || rts_out));

    // R6
    rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CMD_RTS_OFF]) |=> (rts_out == (port_mode != HS_MODE)));

    // R3
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CMD_RX_OFF]) |=> !rx_enable);

    // R4
    fifo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CMD_FIFO_OFF]) |=> !fifo_enable);

    // R1
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(tx_enable) && $stable(rx_enable) && $stable(fifo_enable)
                    && !tx_reset_pulse && !rx_reset_pulse && !status_clear_pulse
                    && !txf_flush_pulse && !rxf_flush_pulse));

endmodule

// File: tb/uart_cmd_ctrl_tb.sv
module uart_cmd_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  port_mode = 2'd0;
    logic        tx_enable, rx_enable, fifo_enable, rts_out;
    logic        tx_reset_pulse, rx_reset_pulse, status_clear_pulse;
    logic        txf_flush_pulse, rxf_flush_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    uart_cmd_ctrl dut_i (
        .clk                (clk),
        .rst_n              (rst_n),
        .wr_en              (wr_en),
        .wr_data            (wr_data),
        .port_mode          (port_mode),
        .tx_enable          (tx_enable),
        .rx_enable          (rx_enable),
        .fifo_enable        (fifo_enable),
        .rts_out            (rts_out),
        .tx_reset_pulse     (tx_reset_pulse),
        .rx_reset_pulse     (rx_reset_pulse),
        .status_clear_pulse (status_clear_pulse),
        .txf_flush_pulse    (txf_flush_pulse),
        .rxf_flush_pulse    (rxf_flush_pulse)
    );

    // observed order: {tx, rx, fifo, rts, txrst, rxrst, stclr, txflush, rxflush}
    function automatic logic [8:0] observed();
        return {tx_enable, rx_enable, fifo_enable, rts_out,
                tx_reset_pulse, rx_reset_pulse, status_clear_pulse,
                txf_flush_pulse, rxf_flush_pulse};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // vector: {data, mode, expected outputs after the write}
    localparam int NV = 23;
    localparam logic [42:0] VEC [NV] = '{
        {32'h0000_0001, 2'd0, 9'b1001_00000},  // R2 tx on
        {32'h0000_0003, 2'd0, 9'b0001_00000},  // R2 on+off -> off
        {32'h0000_0001, 2'd0, 9'b1001_00000},  // R2
        {32'h0000_000C, 2'd0, 9'b1001_00000},  // R3 on+off -> off
        {32'h0000_0004, 2'd0, 9'b1101_00000},  // R3 rx on
        {32'h0000_0000, 2'd0, 9'b1101_00000},  // R1 zero word
        {32'h0000_0030, 2'd0, 9'b1101_00000},  // R4 on+off -> off
        {32'h0000_0010, 2'd0, 9'b1111_00000},  // R4 fifo on
        {32'h0000_0040, 2'd0, 9'b1110_00000},  // R6 mode 0 assert -> low
        {32'h0000_0000, 2'd2, 9'b1111_00000},  // R5 mode 2 active -> high
        {32'h0000_0080, 2'd2, 9'b1110_00000},  // R5 release -> low
        {32'h0000_0040, 2'd2, 9'b1111_00000},  // R5 assert -> high
        {32'h0000_00C0, 2'd0, 9'b1111_00000},  // R6 both -> released, high
        {32'h0000_0100, 2'd0, 9'b1111_10000},  // R8 tx reset
        {32'h0000_0200, 2'd0, 9'b1111_01000},  // R8 rx reset
        {32'h0000_0400, 2'd0, 9'b1111_00100},  // R9 status clear
        {32'h0000_0800, 2'd0, 9'b1111_00010},  // R10 tx flush
        {32'h0000_1000, 2'd0, 9'b1111_00001},  // R10 rx flush
        {32'hFFFF_E000, 2'd0, 9'b1111_00000},  // R11 unassigned bits
        {32'h0000_0022, 2'd0, 9'b0101_00000},  // R12 tx and fifo off
        {32'h0000_0008, 2'd0, 9'b0001_00000},  // R3 rx off
        {32'h0000_1F00, 2'd0, 9'b0001_11111},  // R8 all pulses at once
        {32'h0000_0040, 2'd1, 9'b0000_00000}   // R6 mode 1 is active-low
    };

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [8:0] held;
        repeat (3) @(negedge clk);
        check("R7 reset mode0", observed(), 9'b0001_00000);
        port_mode = 2'd2;
        #1;
        check("R7 reset mode2", observed(), 9'b0000_00000);
        port_mode = 2'd0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            wr_en     = 1'b1;
            wr_data   = VEC[i][42:11];
            port_mode = VEC[i][10:9];
            @(negedge clk);
            check($sformatf("R12 vec %0d", i), observed(), VEC[i][8:0]);
            wr_en   = 1'b0;
            wr_data = '0;
            @(negedge clk);
            check($sformatf("R8 vec %0d pulse gone", i), observed(),
                  {VEC[i][8:5], 5'b00000});
        end

        // R1: strobe low with every command bit set
        port_mode = 2'd2;
        @(negedge clk);
        held = observed();
        wr_data = 32'h0000_1FFF;
        @(negedge clk);
        check("R1 strobe low", observed(), held);
        wr_data = '0;

        // R7: reset mid-operation returns to the idle levels
        wr_en = 1'b1; wr_data = 32'h0000_0055; port_mode = 2'd0;
        @(negedge clk);
        check("R2 R3 R4 all on", observed(), 9'b1110_00000);
        wr_en = 1'b0; wr_data = '0;
        rst_n = 1'b0;
        #1;
        check("R7 async reset", observed(), 9'b0001_00000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after release", observed(), 9'b0001_00000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule